// File: doc/BRIEF.md
# Dual-Bank Numerically Controlled Oscillator

This core is a direct digital synthesis oscillator. A 28-bit phase accumulator grows by a tuning word on every clock. The word comes from one of two frequency banks. A 12-bit phase offset, taken from one of two phase banks, is added to the top accumulator bits. The sum then goes through a three-stage pipeline that produces a 10-bit offset-binary sample. The sample is either a sine built from a computed quarter-wave table or a triangle. The output frequency is the tuning word times the clock rate divided by 2^28.

Software loads the four banks and a control word through a parallel write port. The banks can then be switched from cycle to cycle, either by two select pins or by control bits. This gives frequency and phase modulation without rewriting any bank. A synchronous reset, a sleep input and a sign-bit output complete the block. The sign-bit output shows either the oscillator phase MSB or a comparator bit that arrives from outside the core.

Top module: `nco_dual_bank`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` on the clock edge into the target chosen by `wr_target`: 0 and 1 are frequency banks 0 and 1 (28 bits), 2 and 3 are phase banks 0 and 1 (bits 11:0), 4 is the control word (bits 6:0). Control bits: 0 picks triangle (0 = sine), 1 picks pin-driven selection, 2 is the frequency select bit, 3 is the phase select bit, 4 is the sleep bit, 5 enables the sign output, 6 picks the phase MSB (1) or the comparator bit (0) for the sign output.
- R2: On every edge outside reset, the accumulator grows by the selected frequency word modulo 2^28. A zero word leaves it unchanged.
- R3: With control bit 1 clear, control bit 2 selects the frequency bank and control bit 3 selects the phase bank.
- R4: The selected phase offset is added modulo 4096 to accumulator bits 27:16 to form the presented phase. The offset never enters the accumulator state, so removing it restores the unshifted waveform.
- R5: With control bit 1 set, `freq_pick_pin` and `phase_pick_pin` select the banks. Their value at a rising edge is the one that edge uses.
- R6: Sine: phase bits 9:0 address a quarter wave and are inverted when phase bit 10 is set. The magnitude m(a) is floor(511*16*p / (5*4096^2 - 4*p)) with p = u*(4096-u) and u = 2a+1. The sample is 512+m when phase bit 11 is clear and 512-m when it is set. So phase 0x400 gives 1022, 0xC00 gives 2, and 0x000 and 0x800 give 512.
- R7: Triangle: the low 11 phase bits are inverted when phase bit 11 is set, and the upper 10 of them form the sample. So 0x7FF and 0x800 give 1023, and 0x000 and 0xFFF give 0.
- R8: The accumulator value present after an edge reaches `sample` three edges later. `sample_valid` goes high on the third edge after reset and stays high until the next reset.
- R9: While `rst` is high, the accumulator and pipeline clear, `sample` is 512 and `sample_valid` is low. The banks and the control word keep their contents.
- R10: When `sleep_pin` or control bit 4 is high at an edge, `sample` shows 512 after that edge. The accumulator keeps running meanwhile.
- R11: `sign_out` is 0 while control bit 5 is clear. Otherwise it is `cmp_bit`, or the phase MSB of the sample being shown, as control bit 6 selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset of accumulator and pipeline |
| wr_en | input | 1 | Register write strobe |
| wr_target | input | 3 | Write target code |
| wr_data | input | 28 | Write data |
| freq_pick_pin | input | 1 | Frequency bank select pin |
| phase_pick_pin | input | 1 | Phase bank select pin |
| sleep_pin | input | 1 | Forces midscale output while high |
| cmp_bit | input | 1 | External comparator result |
| sample | output | 10 | Offset-binary waveform sample |
| sample_valid | output | 1 | Pipeline filled since reset |
| sign_out | output | 1 | Sign-bit logic output |

## Verification
The assertions check the rules that hold on every cycle. A zero tuning word freezes the accumulator. Sleep yields midscale on the next cycle. The valid flag clears after reset and then stays set. A sine sample never reaches code zero. Only the bench scenarios can show the sample values themselves. They cover bank switching by pin and by bit, phase offsets that wrap, the table contents at the quadrant edges, and the triangle turnaround. They also cover the waveform resuming after sleep, and a mid-run reset that keeps the loaded banks, which the bench shows by reproducing the same waveform without any rewrite.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Write target codes of the parallel load port.
  typedef enum logic [2:0] {
    TGT_FREQ0  = 3'd0,
    TGT_FREQ1  = 3'd1,
    TGT_PHASE0 = 3'd2,
    TGT_PHASE1 = 3'd3,
    TGT_CTRL   = 3'd4
  } wr_target_e;

  // Control word; the last member sits in bit 0.
  typedef struct packed {
    logic sign_from_nco;  // bit 6
    logic sign_en;        // bit 5
    logic sleep_bit;      // bit 4
    logic phase_bit;      // bit 3
    logic freq_bit;       // bit 2
    logic pin_rule;       // bit 1
    logic tri_wave;       // bit 0
  } ctrl_t;

  // Rational sine approximation for quarter-wave entry a.
  // qbits: address width of the quarter table; amp: peak magnitude.
  function automatic int unsigned quarter_mag(int unsigned a, int unsigned qbits,
                                              int unsigned amp);
    longint unsigned h, u, p, num, den;
    h   = 64'd1 << (qbits + 2);
    u   = 2 * longint'(a) + 1;
    p   = u * (h - u);
    num = longint'(amp) * 16 * p;
    den = 5 * h * h - 4 * p;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs import nco_pkg::*; #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [2:0]            wr_target,
  input  logic [ACC_W-1:0]      wr_data,
  output logic [1:0][ACC_W-1:0] freq_bank,
  output logic [1:0][PH_W-1:0]  phase_bank,
  output ctrl_t                 ctrl
);
  localparam int CW = $bits(ctrl_t);

  // Banks carry no reset: a core reset must leave loaded values intact.
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [ACC_W-1:0] f_q;
    logic [PH_W-1:0]  p_q;
    logic             f_hit, p_hit;
    assign f_hit = wr_en && (wr_target == 3'(int'(TGT_FREQ0) + g));
    assign p_hit = wr_en && (wr_target == 3'(int'(TGT_PHASE0) + g));
    always_ff @(posedge clk) begin
      if (f_hit) f_q <= wr_data;
      if (p_hit) p_q <= wr_data[PH_W-1:0];
    end
    assign freq_bank[g]  = f_q;
    assign phase_bank[g] = p_q;
  end

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_target == TGT_CTRL);

  always_ff @(posedge clk) begin
    if (ctrl_hit) ctrl <= ctrl_t'(wr_data[CW-1:0]);
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0][ACC_W-1:0] freq_bank,
  input  logic [1:0][PH_W-1:0]  phase_bank,
  input  logic                  freq_pick,
  input  logic                  phase_pick,
  output logic [PH_W-1:0]       phase_out
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step_w;
  logic [PH_W-1:0]  offs_w;
  logic [PH_W-1:0]  sum_w;

  function automatic logic [PH_W-1:0] shift_phase(input logic [PH_W-1:0] base,
                                                  input logic [PH_W-1:0] offs);
    return base + offs;  // wraps modulo 2^PH_W
  endfunction

  assign step_w = freq_bank[freq_pick];
  assign offs_w = phase_bank[phase_pick];
  assign sum_w  = shift_phase(acc_q[ACC_W-1 -: PH_W], offs_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      phase_out <= '0;
    end else begin
      acc_q     <= acc_q + step_w;
      phase_out <= sum_w;
    end
  end

  // R2
  zero_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_w == '0) |=> $stable(acc_q));

endmodule

// File: rtl/nco_wave_shaper.sv
module nco_wave_shaper #(
  parameter int PH_W  = 12,
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_in,
  input  logic             tri_sel,
  input  logic             sleep,
  output logic [SMP_W-1:0] sample,
  output logic             sample_valid,
  output logic             nco_msb
);
  localparam int QA   = PH_W - 2;
  localparam int QN   = 1 << QA;
  localparam int MW   = SMP_W - 1;
  localparam int AMP  = (1 << MW) - 1;
  localparam int FILL = 3;
  localparam logic [SMP_W-1:0] MID = {1'b1, {MW{1'b0}}};

  // Quarter-wave magnitude table, computed at elaboration.
  logic [QN*MW-1:0] qrom;
  for (genvar g = 0; g < QN; g++) begin : g_qrom
    localparam int unsigned MAGV = nco_pkg::quarter_mag(g, QA, AMP);
    assign qrom[g*MW +: MW] = MW'(MAGV);
  end

  function automatic logic [QA-1:0] fold_addr(input logic [PH_W-1:0] ph);
    return ph[PH_W-2] ? ~ph[QA-1:0] : ph[QA-1:0];
  endfunction

  function automatic logic [SMP_W-1:0] place_sine(input logic [PH_W-1:0] ph,
                                                  input logic [MW-1:0] mag);
    return ph[PH_W-1] ? (MID - {1'b0, mag}) : (MID + {1'b0, mag});
  endfunction

  function automatic logic [SMP_W-1:0] tri_shape(input logic [PH_W-1:0] ph);
    logic [PH_W-2:0] r;
    r = ph[PH_W-1] ? ~ph[PH_W-2:0] : ph[PH_W-2:0];
    return r[PH_W-2 -: SMP_W];
  endfunction

  logic [PH_W-1:0]  ph2_q;
  logic [QA-1:0]    addr_w;
  logic [MW-1:0]    mag_w;
  logic [SMP_W-1:0] shaped_w;
  logic [FILL-1:0]  fill_q;
  logic             wave_q;

  assign addr_w   = fold_addr(ph2_q);
  assign mag_w    = qrom[int'(addr_w)*MW +: MW];
  assign shaped_w = tri_sel ? tri_shape(ph2_q) : place_sine(ph2_q, mag_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph2_q   <= '0;
      sample  <= MID;
      wave_q  <= 1'b0;
      nco_msb <= 1'b0;
      fill_q  <= '0;
    end else begin
      ph2_q   <= phase_in;
      sample  <= sleep ? MID : shaped_w;
      wave_q  <= tri_sel;
      nco_msb <= ph2_q[PH_W-1];
      fill_q  <= {fill_q[FILL-2:0], 1'b1};
    end
  end

  assign sample_valid = fill_q[FILL-1];

  // R9
  reset_midscale_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sample == MID && !sample_valid));

  // R10
  sleep_midscale_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (sample == MID));

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> sample_valid);

  // R6
  sine_floor_chk: assert property (@(posedge clk) disable iff (rst)
    !wave_q |-> (sample != '0));

endmodule

// File: rtl/nco_dual_bank.sv
module nco_dual_bank import nco_pkg::*; #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_target,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             freq_pick_pin,
  input  logic             phase_pick_pin,
  input  logic             sleep_pin,
  input  logic             cmp_bit,
  output logic [SMP_W-1:0] sample,
  output logic             sample_valid,
  output logic             sign_out
);
  logic [1:0][ACC_W-1:0] freq_bank;
  logic [1:0][PH_W-1:0]  phase_bank;
  ctrl_t                 ctrl;
  logic                  freq_pick, phase_pick, sleep_any, nco_msb;
  logic [PH_W-1:0]       phase_word;

  nco_cfg_regs #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
    .clk(clk), .wr_en(wr_en), .wr_target(wr_target), .wr_data(wr_data),
    .freq_bank(freq_bank), .phase_bank(phase_bank), .ctrl(ctrl)
  );

  // Bank selection: pins when the pin rule is on, control bits otherwise.
  assign freq_pick  = ctrl.pin_rule ? freq_pick_pin  : ctrl.freq_bit;
  assign phase_pick = ctrl.pin_rule ? phase_pick_pin : ctrl.phase_bit;
  assign sleep_any  = sleep_pin | ctrl.sleep_bit;

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .freq_bank(freq_bank), .phase_bank(phase_bank),
    .freq_pick(freq_pick), .phase_pick(phase_pick), .phase_out(phase_word)
  );

  nco_wave_shaper #(.PH_W(PH_W), .SMP_W(SMP_W)) u_shape (
    .clk(clk), .rst(rst), .phase_in(phase_word), .tri_sel(ctrl.tri_wave),
    .sleep(sleep_any), .sample(sample), .sample_valid(sample_valid), .nco_msb(nco_msb)
  );

  assign sign_out = ctrl.sign_en & (ctrl.sign_from_nco ? nco_msb : cmp_bit);

endmodule

// File: tb/sim_nco_dual_bank.sv
module sim_nco_dual_bank;
  localparam int ACC_W = 28;
  localparam int PH_W  = 12;
  localparam int SMP_W = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst, wr_en, fpin, ppin, slp, cmp;
  logic [2:0]       wr_target;
  logic [ACC_W-1:0] wr_data;
  wire  [SMP_W-1:0] sample;
  wire              valid, sgn;

  nco_dual_bank #(.ACC_W(ACC_W), .PH_W(PH_W), .SMP_W(SMP_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_target(wr_target), .wr_data(wr_data),
    .freq_pick_pin(fpin), .phase_pick_pin(ppin), .sleep_pin(slp), .cmp_bit(cmp),
    .sample(sample), .sample_valid(valid), .sign_out(sgn)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string tag    = "R9 reset";

  // Bench-side view of the loaded state and of the pipeline.
  logic [27:0] m_freq [2];
  logic [11:0] m_phase[2];
  logic [6:0]  m_ctrl;
  logic [27:0] m_acc;
  logic [11:0] m_ph1, m_ph2;
  logic [9:0]  m_samp;
  logic [2:0]  m_fill;
  logic        m_msb;

  function automatic int exp_sine(int ph);
    longint pos, u, p, mag;
    pos = ph % 2048;
    u   = 2 * pos + 1;
    p   = u * (4096 - u);
    mag = (511 * 16 * p) / (longint'(5 * 4096 * 4096) - 4 * p);
    return (ph >= 2048) ? 512 - int'(mag) : 512 + int'(mag);
  endfunction

  function automatic int exp_tri(int ph);
    int t;
    t = (ph < 2048) ? ph : 4095 - ph;
    return t / 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic fsel, psel;
    if (rst) begin
      m_acc = '0; m_ph1 = '0; m_ph2 = '0; m_samp = 10'd512; m_fill = '0; m_msb = 1'b0;
    end else begin
      fsel   = m_ctrl[1] ? fpin : m_ctrl[2];
      psel   = m_ctrl[1] ? ppin : m_ctrl[3];
      m_samp = (slp || m_ctrl[4]) ? 10'd512 :
               (m_ctrl[0] ? 10'(exp_tri(int'(m_ph2))) : 10'(exp_sine(int'(m_ph2))));
      m_msb  = m_ph2[11];
      m_ph2  = m_ph1;
      m_ph1  = m_acc[27:16] + m_phase[psel];
      m_acc  = m_acc + m_freq[fsel];
      m_fill = {m_fill[1:0], 1'b1};
    end
    if (wr_en) begin
      case (wr_target)
        3'd0: m_freq[0]  = wr_data;
        3'd1: m_freq[1]  = wr_data;
        3'd2: m_phase[0] = wr_data[11:0];
        3'd3: m_phase[1] = wr_data[11:0];
        3'd4: m_ctrl     = wr_data[6:0];
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    int es;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, int'(sample), int'(m_samp));
    chk("R8 valid", int'(valid), int'(m_fill[2]));
    es = m_ctrl[5] ? (m_ctrl[6] ? int'(m_msb) : int'(cmp)) : 0;
    chk("R11 sign", int'(sgn), es);
  endtask

  task automatic wr(int tgt, int unsigned val);
    wr_en = 1'b1; wr_target = 3'(tgt); wr_data = 28'(val);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic restart();
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  // Steady-phase corner: zero tuning word, given offset, read after fill.
  task automatic corner(string req, int ph, int expv);
    wr(2, 32'(ph));
    restart();
    repeat (3) tick();
    chk(req, int'(sample), expv);
  endtask

  initial begin
    void'($urandom(32'd5821));
    rst = 1'b1; wr_en = 1'b0; wr_target = '0; wr_data = '0;
    fpin = 1'b0; ppin = 1'b0; slp = 1'b0; cmp = 1'b0;

    // Reset state, with loads made while reset is held (R1, R9)
    tag = "R9 reset";
    wr(4, 0); wr(0, 32'h0010000); wr(1, 32'h0023000); wr(2, 0); wr(3, 32'h400);
    tick();
    chk("R9 reset sample", int'(sample), 512);
    chk("R9 reset valid", int'(valid), 0);

    // Accumulation and fill latency (R2, R8)
    rst = 1'b0; tag = "R2 accumulate";
    tick(); tick();
    chk("R8 valid before fill", int'(valid), 0);
    tick();
    chk("R8 valid after fill", int'(valid), 1);
    repeat (60) tick();

    // Table corners with zero tuning word (R1, R6)
    tag = "R6 sine corners";
    wr(0, 0);
    corner("R6 phase 0x400", 32'h400, 1022);
    corner("R6 phase 0xC00", 32'hC00, 2);
    corner("R6 phase 0x000", 32'h000, 512);
    corner("R6 phase 0x800", 32'h800, 512);

    // Triangle corners (R7)
    tag = "R7 triangle corners";
    wr(4, 1);
    corner("R7 phase 0x7FF", 32'h7FF, 1023);
    corner("R7 phase 0x800", 32'h800, 1023);
    corner("R7 phase 0x000", 32'h000, 0);
    corner("R7 phase 0xFFF", 32'hFFF, 0);

    // Triangle running, then phase offset added and removed (R4)
    tag = "R4 offset";
    wr(0, 32'h0054321); wr(2, 0);
    repeat (40) tick();
    wr(2, 32'hA37);
    repeat (40) tick();
    wr(2, 0);
    repeat (40) tick();

    // Bank selection by control bits (R3)
    tag = "R3 bit select";
    wr(1, 32'h0137000); wr(3, 32'h5C1);
    for (int i = 0; i < 40; i++) begin
      wr(4, {$urandom_range(3, 0), 2'b00} | 32'($urandom_range(1, 0)));
      repeat (6) tick();
    end

    // Bank selection by pins, sampled at the edge (R5)
    tag = "R5 pin select";
    wr(4, 32'h02);
    for (int i = 0; i < 300; i++) begin
      fpin = 1'($urandom_range(1, 0));
      ppin = 1'($urandom_range(1, 0));
      tick();
    end

    // Sleep by pin and by bit, accumulator keeps running (R10)
    tag = "R10 sleep";
    slp = 1'b1; repeat (20) tick();
    chk("R10 sleep pin midscale", int'(sample), 512);
    slp = 1'b0; repeat (20) tick();
    wr(4, 32'h12); repeat (20) tick();
    chk("R10 sleep bit midscale", int'(sample), 512);
    wr(4, 32'h02); repeat (20) tick();

    // Reset in mid run keeps every bank (R9)
    tag = "R9 banks kept";
    restart();
    repeat (80) tick();

    // Sign output sources (R11)
    tag = "R11 sign";
    for (int i = 0; i < 8; i++) begin
      wr(4, 32'h20 | 32'h40 * (i % 2) | 32'($urandom_range(1, 0)));
      for (int j = 0; j < 30; j++) begin
        cmp = 1'($urandom_range(1, 0));
        tick();
      end
    end
    wr(4, 32'h40);
    repeat (10) begin cmp = ~cmp; tick(); end

    // Constrained random mix (R1, R2, R3, R5)
    tag = "R2 random";
    for (int i = 0; i < 5000; i++) begin
      fpin = 1'($urandom_range(1, 0));
      ppin = 1'($urandom_range(1, 0));
      cmp  = 1'($urandom_range(1, 0));
      slp  = ($urandom_range(15, 0) == 0);
      rst  = ($urandom_range(299, 0) == 0);
      if ($urandom_range(19, 0) == 0) begin
        int tgt;
        tgt = $urandom_range(4, 0);
        wr(tgt, (tgt == 4) ? ($urandom_range(127, 0) & 32'h6F) : $urandom());
      end else begin
        tick();
      end
    end
    rst = 1'b0; slp = 1'b0;
    repeat (5) tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule